// File: doc/BRIEF.md
# Chunky-to-Planar Transpose Register

This block is a bus slave that turns packed 8-bit pixels into bitplane words. The host pushes a unit of 32 pixels into a single 32-bit data port as eight consecutive writes of four pixels each. It then reads the same port repeatedly. Each read returns one bitplane word, which holds one bit from every pixel of the unit.

The conversion is combinational over the stored unit, so the first plane can be read in the cycle right after the final write. The host may stop reading after fewer than eight planes, as it would for a shallower display. Its next write starts a new unit, and the planes it did not read are dropped.

A second, read-only address returns a fixed identification value. Software uses it to detect that the block is present. The block never starts a transfer of its own, and every access completes in one cycle.

Top module: `c2p_xpose_reg`

## Requirements
- R1: A synchronous active-high reset clears the pixel buffer, both progress counters and `rdata`. After reset, a read of the data address returns zero.
- R2: Eight writes to the data address (address 0) load one unit. In write k (0..7), bits 31:24 carry pixel 4k, bits 23:16 carry pixel 4k+1, bits 15:8 carry pixel 4k+2 and bits 7:0 carry pixel 4k+3.
- R3: Once a unit is loaded, successive data reads return plane 0, then plane 1, and so on up to plane 7. In plane n, bit 31-p equals bit n of pixel p.
- R4: A read in the cycle immediately after the eighth write returns plane 0 without stall. `rdata` is registered and presents the result in the cycle after the read strobe.
- R5: A data read issued before the unit is complete returns zero. It leaves both counters unchanged, so the unit still loads correctly with the remaining writes.
- R6: A data read issued after all eight planes have been read returns zero.
- R7: A data write issued while a unit is loaded, whether or not any planes have been read, starts a fresh unit at pixel 0. Any unread planes are discarded.
- R8: A read of the identification address (address 1) returns 32'h0000CAFE and does not change the conversion state.
- R9: `ready` is high in every cycle.
- R10: A write to the identification address or to any unused address has no effect on the buffer or the counters. If the read and write strobes are asserted together, the write is performed and the read returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address: 0 is data, 1 is identification |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data (four packed pixels) |
| rdata | output | 32 | Registered read data, valid the cycle after `rd_en` |
| ready | output | 1 | Access-complete indication, always high |

## Verification
The assertions watch four things on every cycle:
- an incomplete unit or an exhausted unit reads back as zero;
- the identification value appears after an identification read;
- the eighth write raises the loaded state, and a write into a loaded unit restarts the sequence at slot 1;
- each plane read advances the plane index by one.

The correctness of the transposed bits themselves can only be shown by the bench's scenarios. These include a walking single-pixel sweep over all 32 positions, several arithmetic pixel patterns, and reads issued with no idle cycle after the final write. The scenarios also cover discarding of planes after a partial read, and writes to the identification address leaving the unit intact.

// File: rtl/c2p_pkg.sv
package c2p_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_LOAD,
    ACC_PLANE,
    ACC_IDENT,
    ACC_OTHER
  } acc_e;

  localparam logic [31:0] IDENT_VALUE = 32'h0000CAFE;
endpackage

// File: rtl/c2p_seq.sv
module c2p_seq #(
  parameter int WORDS  = 8,
  parameter int PLANES = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load_i,
  input  logic                        plane_rd_i,
  output logic [$clog2(WORDS)-1:0]    slot_o,
  output logic                        loaded_o,
  output logic                        rd_valid_o,
  output logic [$clog2(PLANES)-1:0]   rd_idx_o
);
  localparam int WC_W = $clog2(WORDS);
  localparam int RC_W = $clog2(PLANES) + 1;
  localparam logic [WC_W-1:0] LAST_SLOT = WC_W'(WORDS - 1);
  localparam logic [RC_W-1:0] ALL_PLANES = RC_W'(PLANES);

  logic [WC_W-1:0] wr_cnt;
  logic [RC_W-1:0] rd_cnt;
  logic            loaded;

  assign slot_o     = loaded ? '0 : wr_cnt;
  assign loaded_o   = loaded;
  assign rd_valid_o = loaded && (rd_cnt < ALL_PLANES);
  assign rd_idx_o   = rd_cnt[RC_W-2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt <= '0;
      rd_cnt <= '0;
      loaded <= 1'b0;
    end else if (load_i) begin
      if (loaded) begin
        wr_cnt <= WC_W'(1);
        rd_cnt <= '0;
        loaded <= 1'b0;
      end else if (wr_cnt == LAST_SLOT) begin
        wr_cnt <= '0;
        loaded <= 1'b1;
      end else begin
        wr_cnt <= wr_cnt + 1'b1;
      end
    end else if (plane_rd_i && rd_valid_o) begin
      rd_cnt <= rd_cnt + 1'b1;
    end
  end

  AST_LOAD_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (load_i && !loaded && wr_cnt == LAST_SLOT) |=> loaded); // R2

  AST_FRESH_UNIT: assert property (@(posedge clk) disable iff (rst)
    (load_i && loaded) |=> (!loaded && wr_cnt == WC_W'(1) && rd_cnt == '0)); // R7

  AST_PLANE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (plane_rd_i && !load_i && rd_valid_o) |=> (rd_cnt == $past(rd_cnt) + 1'b1)); // R3

  AST_EARLY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (plane_rd_i && !load_i && !loaded) |=> (wr_cnt == $past(wr_cnt) && !loaded)); // R5
endmodule

// File: rtl/c2p_pixel_buf.sv
module c2p_pixel_buf #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we_i,
  input  logic [$clog2(WORDS)-1:0]   slot_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [WORDS*DATA_W-1:0]    words_o
);
  logic [DATA_W-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) store[i] <= '0;
    end else if (we_i) begin
      store[slot_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_flat
    assign words_o[g*DATA_W +: DATA_W] = store[g];
  end
endmodule

// File: rtl/c2p_transpose.sv
module c2p_transpose #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int PIX_W  = 8
) (
  input  logic [WORDS*DATA_W-1:0]  words_i,
  output logic [PIX_W*DATA_W-1:0]  planes_o
);
  localparam int PPW      = DATA_W / PIX_W;
  localparam int UNIT_PIX = WORDS * PPW;

  for (genvar p = 0; p < UNIT_PIX; p++) begin : g_pix
    for (genvar n = 0; n < PIX_W; n++) begin : g_bit
      assign planes_o[n*DATA_W + (DATA_W-1-p)] =
        words_i[(p/PPW)*DATA_W + DATA_W - ((p%PPW)+1)*PIX_W + n];
    end
  end
endmodule

// File: rtl/c2p_xpose_reg.sv
module c2p_xpose_reg
  import c2p_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int PIX_W     = 8,
  parameter int WORDS     = 8,
  parameter int DATA_ADDR = 0,
  parameter int ID_ADDR   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready
);
  localparam int PLANES = PIX_W;
  localparam int WC_W   = $clog2(WORDS);
  localparam int PC_W   = $clog2(PLANES);

  acc_e                   acc;
  logic [WC_W-1:0]        slot;
  logic                   loaded;
  logic                   rd_valid;
  logic [PC_W-1:0]        rd_idx;
  logic [WORDS*DATA_W-1:0] words;
  logic [PIX_W*DATA_W-1:0] planes;

  always_comb begin
    acc = ACC_NONE;
    if (wr_en) begin
      acc = (addr == ADDR_W'(DATA_ADDR)) ? ACC_LOAD : ACC_OTHER;
    end else if (rd_en) begin
      if (addr == ADDR_W'(DATA_ADDR))    acc = ACC_PLANE;
      else if (addr == ADDR_W'(ID_ADDR)) acc = ACC_IDENT;
      else                               acc = ACC_OTHER;
    end
  end

  c2p_seq #(.WORDS(WORDS), .PLANES(PLANES)) seq_i (
    .clk(clk), .rst(rst),
    .load_i(acc == ACC_LOAD), .plane_rd_i(acc == ACC_PLANE),
    .slot_o(slot), .loaded_o(loaded), .rd_valid_o(rd_valid), .rd_idx_o(rd_idx)
  );

  c2p_pixel_buf #(.WORDS(WORDS), .DATA_W(DATA_W)) buf_i (
    .clk(clk), .rst(rst), .we_i(acc == ACC_LOAD),
    .slot_i(slot), .wdata_i(wdata), .words_o(words)
  );

  c2p_transpose #(.WORDS(WORDS), .DATA_W(DATA_W), .PIX_W(PIX_W)) xp_i (
    .words_i(words), .planes_o(planes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (acc)
        ACC_PLANE: rdata <= rd_valid ? planes[rd_idx*DATA_W +: DATA_W] : '0;
        ACC_IDENT: rdata <= DATA_W'(IDENT_VALUE);
        default:   rdata <= '0;
      endcase
    end
  end

  assign ready = 1'b1;

  AST_EARLY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_PLANE && !loaded) |=> (rdata == '0)); // R5

  AST_SPENT_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_PLANE && loaded && !rd_valid) |=> (rdata == '0)); // R6

  AST_IDENT_VALUE: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_IDENT) |=> (rdata == DATA_W'(IDENT_VALUE))); // R8

  AST_COLLIDE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en) |=> (rdata == '0)); // R10
endmodule

// File: tb/c2p_xpose_reg_tb_top.sv
module c2p_xpose_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  addr;
  logic        wr_en, rd_en;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        ready;

  int errors = 0;
  int checks = 0;

  logic [7:0]  pix [32];
  logic [31:0] got;

  always #10 clk = ~clk;

  c2p_xpose_reg dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .ready(ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1; wr_en = 1'b0;
    @(posedge clk); #1;
    d = rdata;
    rd_en = 1'b0;
  endtask

  function automatic logic [31:0] word_of(input int k);
    return {pix[4*k], pix[4*k+1], pix[4*k+2], pix[4*k+3]};
  endfunction

  function automatic logic [31:0] plane_of(input int n);
    logic [31:0] v = '0;
    for (int p = 0; p < 32; p++) v[31-p] = pix[p][n];
    return v;
  endfunction

  task automatic load_unit();
    for (int k = 0; k < 8; k++) bus_wr(4'd0, word_of(k));
  endtask

  task automatic read_planes(input int count, input string req);
    for (int n = 0; n < count; n++) begin
      bus_rd(4'd0, got);
      chk(req, got, plane_of(n));
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rdata after reset", rdata, 32'h0);
    chk("R9 ready in reset", {31'h0, ready}, 32'h1);
    @(negedge clk); rst = 1'b0;
    bus_rd(4'd0, got);
    chk("R1 empty read", got, 32'h0);
    bus_rd(4'd1, got);
    chk("R8 ident", got, 32'h0000CAFE);
    chk("R9 ready", {31'h0, ready}, 32'h1);

    // R2 R3 R4: walking single bright pixel over every position
    for (int k = 0; k < 32; k++) begin
      for (int p = 0; p < 32; p++) pix[p] = (p == k) ? 8'hFF : 8'h00;
      load_unit();
      read_planes(8, "R3 walking pixel");
    end

    // R2 R3 R4: arithmetic patterns, first read right after last write
    for (int s = 0; s < 6; s++) begin
      for (int p = 0; p < 32; p++) pix[p] = 8'((p * (2*s+3) + s * 29) ^ (s * 17));
      load_unit();
      bus_rd(4'd0, got);
      chk("R4 plane0 back-to-back", got, plane_of(0));
      for (int n = 1; n < 8; n++) begin
        bus_rd(4'd0, got);
        chk("R2 pattern plane", got, plane_of(n));
      end
      bus_rd(4'd0, got);
      chk("R6 ninth read", got, 32'h0);
      bus_rd(4'd0, got);
      chk("R6 tenth read", got, 32'h0);
    end

    // R5: early reads do not disturb loading
    for (int p = 0; p < 32; p++) pix[p] = 8'(p * 8 + 5);
    for (int k = 0; k < 3; k++) bus_wr(4'd0, word_of(k));
    bus_rd(4'd0, got);
    chk("R5 early read", got, 32'h0);
    bus_rd(4'd1, got);
    chk("R8 ident mid-unit", got, 32'h0000CAFE);
    // R10: write to ident and unused address ignored
    bus_wr(4'd1, 32'hDEADBEEF);
    bus_wr(4'd9, 32'h12345678);
    for (int k = 3; k < 8; k++) bus_wr(4'd0, word_of(k));
    read_planes(8, "R5 R10 unit intact");

    // R7: partial read then new unit discards the rest
    for (int p = 0; p < 32; p++) pix[p] = 8'(255 - p * 3);
    load_unit();
    read_planes(6, "R7 partial");
    for (int p = 0; p < 32; p++) pix[p] = 8'(p * 41 + 7);
    load_unit();
    read_planes(8, "R7 fresh after partial");

    // R7: write while loaded with no reads restarts
    for (int p = 0; p < 32; p++) pix[p] = 8'hA5;
    load_unit();
    for (int p = 0; p < 32; p++) pix[p] = 8'(p ^ 8'h3C);
    load_unit();
    read_planes(8, "R7 reload without reads");

    // R10: simultaneous strobes, write wins, read returns zero
    for (int p = 0; p < 32; p++) pix[p] = 8'(p * 13);
    for (int k = 0; k < 7; k++) bus_wr(4'd0, word_of(k));
    @(negedge clk);
    addr = 4'd0; wdata = word_of(7); wr_en = 1'b1; rd_en = 1'b1;
    @(posedge clk); #1;
    chk("R10 collide read", rdata, 32'h0);
    wr_en = 1'b0; rd_en = 1'b0;
    read_planes(8, "R10 collide write taken");
    chk("R9 ready end", {31'h0, ready}, 32'h1);

    // R1: reset mid-unit
    for (int k = 0; k < 8; k++) bus_wr(4'd0, word_of(k));
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 rdata cleared", rdata, 32'h0);
    @(negedge clk); rst = 1'b0;
    bus_rd(4'd0, got);
    chk("R1 unit dropped", got, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule